// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Sequencer

This block frees a two-wire serial bus that a target device has left hung, most often with the data line held low in the middle of a byte. A single-cycle start request begins a recovery run. During the run the block holds the attached bus master controller in reset, so the controller cannot fight the recovery for the wires. The block lets both lines float and gives them a settle period. It then checks whether clock and data both read high. Whenever the bus is still not free, it pulls the clock line low for a programmed number of cycles and lets it go again. The extra clock edges let the target finish the byte it thinks is still in flight, and then it releases data.

The block stops clocking as soon as the bus reads free, and it never makes more than a fixed number of attempts. At the end it releases the controller reset and raises a one-cycle done pulse. A failure flag comes with the pulse: it is set when the bus is still not free after the final attempt. The flag holds its value until the next accepted start.

The outputs are open-drain drive enables: a 1 pulls the line low, and a 0 leaves it to the pull-up. The two line inputs pass through synchroniser flops before the block looks at them. The low-pulse width and the release width are both set by one clock-count parameter. For example, 500 cycles gives 10 µs at a 50 MHz clock.

Top module: `bus_unstick_seq`

## Requirements
- R1: After reset, both drive enables are 0, the controller reset output is 0, and done and fail are 0.
- R2: An accepted start raises the controller reset output in the next cycle. It stays high on every cycle until done. In the done cycle it is already 0.
- R3: The bus counts as free only when the synchronised SDA and SCL both read 1. If the bus is free at the first check, the run ends with fail=0 and no SCL low pulse.
- R4: The SDA drive enable is never 1. After start, both lines stay released for PULSE_CYCLES cycles plus one check cycle before the first SCL low pulse.
- R5: Each attempt drives SCL low for exactly PULSE_CYCLES cycles. SCL is then released for PULSE_CYCLES cycles plus one check cycle before the next decision.
- R6: The line state is checked again before every attempt. Clocking stops at the first check that finds the bus free, so the number of pulses equals the number the target needed.
- R7: At most MAX_TRIES attempts are made. A run whose check after the last attempt still finds the bus not free ends with fail=1. A run in which that check finds the bus free ends with fail=0.
- R8: SCL held low by the outside world with SDA high counts as not free. Such a run makes MAX_TRIES attempts and ends with fail=1.
- R9: A start that arrives while a run is in progress, including the done cycle, is ignored: it neither restarts nor lengthens the run, and it does not begin a new one.
- R10: Done is a single-cycle pulse. Fail holds its value until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a recovery run |
| scl_in_i | input | 1 | Sampled SCL line level (asynchronous) |
| sda_in_i | input | 1 | Sampled SDA line level (asynchronous) |
| scl_drive_low_o | output | 1 | 1 pulls SCL low; 0 releases it |
| sda_drive_low_o | output | 1 | 1 pulls SDA low; 0 releases it |
| ctrl_rst_o | output | 1 | Holds the bus master controller in reset during a run |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| fail_o | output | 1 | Bus still stuck at the end of the last run |

## Verification
Two functions can fall in the same cycle: the attempt limit running out, and the bus becoming free.

The bench provokes this with a modelled target that lets SDA go only after exactly MAX_TRIES clock edges. The run must end with fail=0 after MAX_TRIES pulses. One edge more must end with fail=1 after the same number of pulses.

The bench also raises start in the very cycle done is high. It judges that nothing happened by seeing the controller reset stay low and fail keep its value.

// File: rtl/bus_rcv_pkg.sv
package bus_rcv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_CHECK,
        ST_LOW,
        ST_HIGH,
        ST_FINISH
    } rcv_state_e;

endpackage

// File: rtl/bus_rcv_sync.sv
module bus_rcv_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] async_i,
    output logic [LINES-1:0] sync_o
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        assign sync_o[g] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/bus_rcv_timer.sv
module bus_rcv_timer #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] load_val_i,
    output logic             expired_o
);

    logic [WIDTH-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)           cnt_d = load_val_i;
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

    AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q == '0) |=> (cnt_q == '0));  // R5

endmodule

// File: rtl/bus_unstick_seq.sv
module bus_unstick_seq
    import bus_rcv_pkg::*;
#(
    parameter int PULSE_CYCLES = 500,
    parameter int MAX_TRIES    = 100,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic scl_in_i,
    input  logic sda_in_i,
    output logic scl_drive_low_o,
    output logic sda_drive_low_o,
    output logic ctrl_rst_o,
    output logic done_o,
    output logic fail_o
);

    localparam int TMR_W = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
    localparam int TRY_W = $clog2(MAX_TRIES + 1);
    localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(PULSE_CYCLES - 1);
    localparam logic [TRY_W-1:0] TRY_MAX  = TRY_W'(MAX_TRIES);

    typedef struct packed {
        rcv_state_e       state;
        logic [TRY_W-1:0] tries;
        logic             fail;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [1:0] lines_s;
    logic       bus_free;
    logic       tmr_load;
    logic       tmr_expired;

    bus_rcv_sync #(
        .STAGES (SYNC_STAGES),
        .LINES  (2)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({scl_in_i, sda_in_i}),
        .sync_o  (lines_s)
    );

    assign bus_free = lines_s[1] & lines_s[0];

    bus_rcv_timer #(
        .WIDTH (TMR_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (TMR_LOAD),
        .expired_o  (tmr_expired)
    );

    always_comb begin
        ctl_d    = ctl_q;
        tmr_load = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.state = ST_SETTLE;
                    ctl_d.tries = '0;
                    ctl_d.fail  = 1'b0;
                    tmr_load    = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (tmr_expired) ctl_d.state = ST_CHECK;
            end
            ST_CHECK: begin
                if (bus_free) begin
                    ctl_d.state = ST_FINISH;
                    ctl_d.fail  = 1'b0;
                end else if (ctl_q.tries == TRY_MAX) begin
                    ctl_d.state = ST_FINISH;
                    ctl_d.fail  = 1'b1;
                end else begin
                    ctl_d.state = ST_LOW;
                    ctl_d.tries = ctl_q.tries + 1'b1;
                    tmr_load    = 1'b1;
                end
            end
            ST_LOW: begin
                if (tmr_expired) begin
                    ctl_d.state = ST_HIGH;
                    tmr_load    = 1'b1;
                end
            end
            ST_HIGH: begin
                if (tmr_expired) ctl_d.state = ST_CHECK;
            end
            ST_FINISH: begin
                ctl_d.state = ST_IDLE;
            end
            default: begin
                ctl_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state <= ST_IDLE;
            ctl_q.tries <= '0;
            ctl_q.fail  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign scl_drive_low_o = (ctl_q.state == ST_LOW);
    assign sda_drive_low_o = 1'b0;
    assign ctrl_rst_o      = (ctl_q.state == ST_SETTLE) || (ctl_q.state == ST_CHECK) ||
                             (ctl_q.state == ST_LOW)    || (ctl_q.state == ST_HIGH);
    assign done_o          = (ctl_q.state == ST_FINISH);
    assign fail_o          = ctl_q.fail;

    AST_RST_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(ctrl_rst_o));  // R2
    AST_FREE_ENDS_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_CHECK && bus_free) |=> (done_o && !fail_o && !scl_drive_low_o));  // R3
    AST_PULSE_AFTER_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_drive_low_o) |-> ($past(ctl_q.state) == ST_CHECK && !$past(bus_free)));  // R6
    AST_TRIES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.tries <= TRY_MAX);  // R7
    AST_FAIL_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fail_o) |-> (ctl_q.tries == TRY_MAX));  // R7
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && ctl_q.state != ST_IDLE) |=> (ctl_q.state != ST_SETTLE));  // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);  // R10

endmodule

// File: tb/bus_unstick_seq_bench.sv
module bus_unstick_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int P          = 4;
    localparam int MAXT       = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic scl_drv, sda_drv, ctrl_rst, done, fail;
    logic scl_line, sda_line;

    bit scl_stuck = 1'b0;
    bit sda_hold  = 1'b0;
    bit armed     = 1'b0;
    int release_after = 0;
    int edges = 0;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    bit mon_en = 1'b0;
    bit prev_drv = 1'b0;
    int pulses = 0, run_low = 0, gap = 0;
    int width_bad = 0, gap_bad = 0, rst_drop = 0, sda_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign scl_line = !scl_drv && !scl_stuck;
    assign sda_line = !sda_drv && !sda_hold;

    bus_unstick_seq #(
        .PULSE_CYCLES (P),
        .MAX_TRIES    (MAXT),
        .SYNC_STAGES  (2)
    ) u_bus_unstick_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start),
        .scl_in_i        (scl_line),
        .sda_in_i        (sda_line),
        .scl_drive_low_o (scl_drv),
        .sda_drive_low_o (sda_drv),
        .ctrl_rst_o      (ctrl_rst),
        .done_o          (done),
        .fail_o          (fail)
    );

    // Target model: lets SDA go after a set number of SCL rising edges
    always @(posedge scl_line) begin
        if (armed && sda_hold) begin
            edges = edges + 1;
            if (edges >= release_after) sda_hold = 1'b0;
        end
    end

    // Line monitor, sampled away from the active edge
    always @(negedge clk) begin
        cycles = cycles + 1;
        if (mon_en) begin
            if (sda_drv) sda_seen = sda_seen + 1;
            if (!ctrl_rst && !done) rst_drop = rst_drop + 1;
            if (scl_drv) begin
                if (!prev_drv) begin
                    pulses = pulses + 1;
                    if (gap != P + 1) gap_bad = gap_bad + 1;
                    gap = 0;
                end
                run_low = run_low + 1;
            end else begin
                if (prev_drv && run_low != P) width_bad = width_bad + 1;
                run_low = 0;
                if (ctrl_rst) gap = gap + 1;
            end
            prev_drv = scl_drv;
        end
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles, expected under 150000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests = tests + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic test_reset();
        check(scl_drv == 1'b0, "R1 scl drive", int'(scl_drv), 0);
        check(sda_drv == 1'b0, "R1 sda drive", int'(sda_drv), 0);
        check(ctrl_rst == 1'b0, "R1 ctrl reset", int'(ctrl_rst), 0);
        check(done == 1'b0, "R1 done", int'(done), 0);
        check(fail == 1'b0, "R1 fail", int'(fail), 0);
    endtask

    task automatic run_case(input string tag, input int hold_edges, input bit stk,
                            input int exp_pulses, input bit exp_fail, input bit poke_mid);
        int waited;
        @(negedge clk);
        sda_hold      = (hold_edges > 0);
        release_after = hold_edges;
        edges         = 0;
        scl_stuck     = stk;
        armed         = 1'b1;
        pulses = 0; run_low = 0; gap = 0; prev_drv = 1'b0;
        width_bad = 0; gap_bad = 0; rst_drop = 0; sda_seen = 0;
        start = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        mon_en = 1'b1;
        check(ctrl_rst == 1'b1, {tag, " R2 reset raised"}, int'(ctrl_rst), 1);
        check(fail == 1'b0, {tag, " R10 fail cleared by start"}, int'(fail), 0);
        waited = 0;
        while (!done && waited < 5000) begin
            if (poke_mid && waited == 20) start = 1'b1;
            else start = 1'b0;
            @(negedge clk);
            waited = waited + 1;
        end
        start = 1'b0;
        check(done == 1'b1, {tag, " R2 done reached"}, int'(done), 1);
        check(ctrl_rst == 1'b0, {tag, " R2 reset low at done"}, int'(ctrl_rst), 0);
        check(fail == exp_fail, {tag, " R7 fail status"}, int'(fail), int'(exp_fail));
        check(pulses == exp_pulses, {tag, " R6 pulse count"}, pulses, exp_pulses);
        check(width_bad == 0, {tag, " R5 low width"}, width_bad, 0);
        check(gap_bad == 0, {tag, " R4 release before pulse"}, gap_bad, 0);
        check(rst_drop == 0, {tag, " R2 reset held"}, rst_drop, 0);
        check(sda_seen == 0, {tag, " R4 sda never driven"}, sda_seen, 0);
        mon_en = 1'b0;
        // start during the done cycle must be ignored
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, {tag, " R10 done single cycle"}, int'(done), 0);
        check(ctrl_rst == 1'b0, {tag, " R9 start at done ignored"}, int'(ctrl_rst), 0);
        repeat (P + 3) @(negedge clk);
        check(ctrl_rst == 1'b0 && !scl_drv, {tag, " R9 no new run"}, int'(ctrl_rst), 0);
        check(fail == exp_fail, {tag, " R10 fail held"}, int'(fail), int'(exp_fail));
        armed     = 1'b0;
        sda_hold  = 1'b0;
        scl_stuck = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        test_reset();
        run_case("free_bus R3", 0, 1'b0, 0, 1'b0, 1'b0);
        run_case("one_edge R6", 1, 1'b0, 1, 1'b0, 1'b0);
        run_case("nine_edges_poke R9", 9, 1'b0, 9, 1'b0, 1'b1);
        run_case("limit_frees R7", MAXT, 1'b0, MAXT, 1'b0, 1'b0);
        run_case("limit_stuck R7", MAXT + 1, 1'b0, MAXT, 1'b1, 1'b0);
        run_case("scl_held R8", 0, 1'b1, MAXT, 1'b1, 1'b0);
        run_case("after_fail R10", 0, 1'b0, 0, 1'b0, 1'b0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule